// File: doc/BRIEF.md
# Audio Sample Alignment Packer

This block sits between a 32-bit AXI4-Stream data path and the per-slot sample interface of an audio serial port. On the transmit side it takes stream words and hands out one sample per slot at the configured sample size. On the receive side it gathers captured slot samples into stream words for the system. A sample can sit at the top of its 32-bit container or at the bottom. At the bottom, the receive path sign-extends it and the transmit path ignores the spare upper bits.

Small samples can be packed to save bandwidth. With packing on, 8-bit samples go four to a word and 16-bit samples go two to a word, the earliest sample in the lowest lane. Every other size keeps one sample per word. Frame boundaries are carried by `tlast` on the stream side and by a last-slot flag on the sample side. A partly filled receive word is padded with zeros and sent out when its frame ends or when the block is switched off. Received words queue in a small FIFO, held in a memory that can map to block RAM, before they reach the stream master port.

Top module: `audio_align_packer`

## Requirements
- R1: Size code `cfg_size` selects the sample width: 0=8, 1=16, 2=18, 3=20, 4=24, 5=32 bits (6 and 7 also mean 32). With `cfg_packed`=0 every stream word carries exactly one sample.
- R2: Transmit, one sample per word, `cfg_left`=1: the sample is the top N bits of the stream word. It appears on `tx_smp_data[N-1:0]` with all higher bits zero.
- R3: Transmit, one sample per word, `cfg_left`=0: the sample is the bottom N bits of the stream word. The word's upper bits are ignored, and `tx_smp_data` above bit N-1 is zero.
- R4: Receive, one sample per word, `cfg_left`=1: the stream word is `rx_smp_data[N-1:0]` placed in bits 31 down to 32-N, with all lower bits zero.
- R5: Receive, one sample per word, `cfg_left`=0: the stream word is `rx_smp_data[N-1:0]` sign-extended from bit N-1 to 32 bits. Input bits above N-1 are ignored.
- R6: Transmit, packed, size 8 or 16: a word yields four 8-bit or two 16-bit samples, in order from bits 7:0 (or 15:0) upward.
- R7: Receive, packed, size 8 or 16: four 8-bit or two 16-bit samples fill a word, the first in bits 7:0 (or 15:0) and later samples in the next higher lanes.
- R8: With `cfg_packed`=1, sizes 18, 20, 24 and 32 behave exactly as one sample per word.
- R9: Frame marking. On transmit, `tx_smp_last` is 1 on the final sample taken from a stream word that had `s_axis_tlast`=1, and 0 otherwise. On receive, the word that holds a sample flagged `rx_smp_last` carries `m_axis_tlast`=1, and no other word does.
- R10: A sample flagged `rx_smp_last` ends its word at once. Lanes not yet filled are zero.
- R11: While `cfg_enable`=0, `s_axis_tready` and `rx_smp_ready` are 0 and a held transmit word is dropped. A partly filled receive word is sent zero-padded with `m_axis_tlast`=0.
- R12: Both outputs follow valid/ready flow control. A presented sample or word stays unchanged until it is taken. The receive path buffers FIFO_DEPTH+1 words and then pulls `rx_smp_ready` low rather than lose data.
- R13: After reset, `tx_smp_valid` and `m_axis_tvalid` are 0. With `cfg_enable`=1, both `s_axis_tready` and `rx_smp_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Block enable; low drops transmit state and flushes receive state |
| cfg_size | input | 3 | Sample size code |
| cfg_left | input | 1 | 1 = sample at top of container, 0 = at bottom |
| cfg_packed | input | 1 | 1 = pack 8/16-bit samples several per word |
| s_axis_tdata | input | 32 | Transmit stream word |
| s_axis_tvalid | input | 1 | Transmit stream word valid |
| s_axis_tlast | input | 1 | Transmit stream word ends a frame |
| s_axis_tready | output | 1 | Block accepts a transmit word |
| tx_smp_data | output | 32 | Transmit sample, in the low bits |
| tx_smp_valid | output | 1 | Transmit sample valid |
| tx_smp_last | output | 1 | Transmit sample is the frame's final slot |
| tx_smp_ready | input | 1 | Serial port takes the sample |
| rx_smp_data | input | 32 | Captured sample, in the low bits |
| rx_smp_valid | input | 1 | Captured sample valid |
| rx_smp_last | input | 1 | Captured sample is the frame's final slot |
| rx_smp_ready | output | 1 | Block accepts a captured sample |
| m_axis_tdata | output | 32 | Receive stream word |
| m_axis_tvalid | output | 1 | Receive stream word valid |
| m_axis_tlast | output | 1 | Receive stream word ends a frame |
| m_axis_tready | input | 1 | Downstream takes the word |

## Verification
A stuck or skipped transmit lane index shows up within the first packed word: samples come out repeated, missing or in the wrong order on `tx_smp_data`. If the receive accumulator or lane counter fails to clear, the next word carries stale bits OR'd into it, or a lane lands in the wrong place, so the fault is visible one word after the frame end or flush that should have cleared it. FIFO pointer or count faults appear only once the buffer wraps or fills. They show as repeated or stale words on `m_axis_tdata`, or as `rx_smp_ready` dropping at the wrong fill level, so the bench stalls the stream output until the queue is full.

// File: rtl/align_pkg.sv
package align_pkg;
  localparam int STREAM_W = 32;

  typedef enum logic [2:0] {
    SZ_8  = 3'd0,
    SZ_16 = 3'd1,
    SZ_18 = 3'd2,
    SZ_20 = 3'd3,
    SZ_24 = 3'd4,
    SZ_32 = 3'd5
  } size_code_e;

  // Sample width in bits for a size code (R1)
  function automatic int sample_bits(input logic [2:0] code);
    case (code)
      SZ_8:    return 8;
      SZ_16:   return 16;
      SZ_18:   return 18;
      SZ_20:   return 20;
      SZ_24:   return 24;
      default: return 32;
    endcase
  endfunction

  // Samples per stream word (R6, R7, R8)
  function automatic logic [2:0] lanes_per_word(input logic [2:0] code, input logic pk);
    if (pk && code == SZ_8)  return 3'd4;
    if (pk && code == SZ_16) return 3'd2;
    return 3'd1;
  endfunction

  function automatic logic [STREAM_W-1:0] low_mask(input int bits);
    return ~({STREAM_W{1'b1}} << bits);
  endfunction
endpackage

// File: rtl/align_tx_unpack.sv
module align_tx_unpack
  import align_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [2:0]          cfg_size,
  input  logic                cfg_left,
  input  logic                cfg_packed,
  input  logic [STREAM_W-1:0] s_tdata,
  input  logic                s_tvalid,
  input  logic                s_tlast,
  output logic                s_tready,
  output logic [STREAM_W-1:0] smp_data,
  output logic                smp_valid,
  output logic                smp_last,
  input  logic                smp_ready
);
  logic [STREAM_W-1:0] hold_data;
  logic                hold_last;
  logic                hold_vld;
  logic [1:0]          lane_idx;
  logic [2:0]          lanes_n;
  logic [STREAM_W-1:0] extract;
  logic                last_lane;
  logic                advance;
  int                  bits;

  assign lanes_n   = lanes_per_word(cfg_size, cfg_packed);
  assign bits      = sample_bits(cfg_size);
  assign last_lane = ({1'b0, lane_idx} == lanes_n - 3'd1);
  assign advance   = hold_vld && (!smp_valid || smp_ready);
  assign s_tready  = en && !hold_vld;

  always_comb begin
    case (lanes_n)
      3'd4:    extract = (hold_data >> {lane_idx, 3'b000}) & low_mask(8);
      3'd2:    extract = (hold_data >> {lane_idx, 4'b0000}) & low_mask(16);
      default: extract = cfg_left ? (hold_data >> (STREAM_W - bits))
                                  : (hold_data & low_mask(bits));
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hold_data <= '0;
      hold_last <= 1'b0;
      hold_vld  <= 1'b0;
      lane_idx  <= '0;
      smp_data  <= '0;
      smp_valid <= 1'b0;
      smp_last  <= 1'b0;
    end else begin
      if (smp_valid && smp_ready) smp_valid <= 1'b0;
      if (advance) begin
        smp_data  <= extract;
        smp_valid <= 1'b1;
        smp_last  <= hold_last && last_lane;
        if (last_lane) begin
          hold_vld <= 1'b0;
          lane_idx <= '0;
        end else begin
          lane_idx <= lane_idx + 2'd1;
        end
      end
      if (s_tvalid && s_tready) begin
        hold_data <= s_tdata;
        hold_last <= s_tlast;
        hold_vld  <= 1'b1;
        lane_idx  <= '0;
      end
    end
  end

  // R6: lane index never passes the lane count of the current mode
  a_r6_lane_in_range: assert property (@(posedge clk) disable iff (rst)
    hold_vld |-> ({1'b0, lane_idx} < lanes_n));

  // R12: a presented sample holds until the serial port takes it
  a_r12_tx_sample_stable: assert property (@(posedge clk) disable iff (rst || !en)
    smp_valid && !smp_ready |=> smp_valid && $stable(smp_data) && $stable(smp_last));

  // R3: nothing above the sample width reaches the serial port
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> ((smp_data & ~low_mask(sample_bits(cfg_size))) == '0));
endmodule

// File: rtl/align_rx_pack.sv
module align_rx_pack
  import align_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [2:0]          cfg_size,
  input  logic                cfg_left,
  input  logic                cfg_packed,
  input  logic [STREAM_W-1:0] smp_data,
  input  logic                smp_valid,
  input  logic                smp_last,
  output logic                smp_ready,
  input  logic                fifo_full,
  output logic                push,
  output logic [STREAM_W-1:0] push_data,
  output logic                push_last
);
  logic [STREAM_W-1:0] acc;
  logic [1:0]          cnt;
  logic [2:0]          lanes_n;
  logic [STREAM_W-1:0] placed;
  logic [STREAM_W-1:0] msk;
  logic                sign_bit;
  logic                take;
  logic                complete;
  logic                flush;
  int                  bits;

  assign lanes_n  = lanes_per_word(cfg_size, cfg_packed);
  assign bits     = sample_bits(cfg_size);
  assign msk      = low_mask(bits);
  assign sign_bit = smp_data[bits-1];

  always_comb begin
    case (lanes_n)
      3'd4:    placed = (smp_data & low_mask(8))  << {cnt, 3'b000};
      3'd2:    placed = (smp_data & low_mask(16)) << {cnt, 4'b0000};
      default: placed = cfg_left ? ((smp_data & msk) << (STREAM_W - bits))
                                 : ((smp_data & msk) | (sign_bit ? ~msk : '0));
    endcase
  end

  assign smp_ready = en && !fifo_full;
  assign take      = smp_valid && smp_ready;
  assign complete  = take && (({1'b0, cnt} == lanes_n - 3'd1) || smp_last);
  assign flush     = !en && (cnt != 2'd0) && !fifo_full;
  assign push      = complete || flush;
  assign push_data = complete ? (acc | placed) : acc;
  assign push_last = complete && smp_last;

  always_ff @(posedge clk) begin
    if (rst || push) begin
      acc <= '0;
      cnt <= '0;
    end else if (take) begin
      acc <= acc | placed;
      cnt <= cnt + 2'd1;
    end
  end

  // R7: lane counter stays inside the word
  a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    (cnt != 2'd0) |-> ({1'b0, cnt} < lanes_n));

  // R10: a frame-end sample leaves no partial word behind
  a_r10_frame_end_clears: assert property (@(posedge clk) disable iff (rst)
    smp_valid && smp_ready && smp_last |=> (cnt == 2'd0));
endmodule

// File: rtl/align_word_fifo.sv
module align_word_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  output logic         full,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  input  logic         out_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [AW:0]   count;
  logic          empty;
  logic          pop;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign pop   = !empty && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (pop) out_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (wr)  wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({wr, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (pop)                  out_valid <= 1'b1;
      else if (out_ready)       out_valid <= 1'b0;
    end
  end

  // R12: the packer never writes into a full queue
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr |-> !full);

  // R12: a presented stream word holds until taken
  a_r12_word_stable: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/audio_align_packer.sv
module audio_align_packer
  import align_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_enable,
  input  logic [2:0]          cfg_size,
  input  logic                cfg_left,
  input  logic                cfg_packed,
  input  logic [STREAM_W-1:0] s_axis_tdata,
  input  logic                s_axis_tvalid,
  input  logic                s_axis_tlast,
  output logic                s_axis_tready,
  output logic [STREAM_W-1:0] tx_smp_data,
  output logic                tx_smp_valid,
  output logic                tx_smp_last,
  input  logic                tx_smp_ready,
  input  logic [STREAM_W-1:0] rx_smp_data,
  input  logic                rx_smp_valid,
  input  logic                rx_smp_last,
  output logic                rx_smp_ready,
  output logic [STREAM_W-1:0] m_axis_tdata,
  output logic                m_axis_tvalid,
  output logic                m_axis_tlast,
  input  logic                m_axis_tready
);
  localparam int FW = STREAM_W + 1;

  logic                push;
  logic [STREAM_W-1:0] push_data;
  logic                push_last;
  logic                fifo_full;
  logic [FW-1:0]       fifo_out;

  align_tx_unpack i_tx (
    .clk        (clk),
    .rst        (rst),
    .en         (cfg_enable),
    .cfg_size   (cfg_size),
    .cfg_left   (cfg_left),
    .cfg_packed (cfg_packed),
    .s_tdata    (s_axis_tdata),
    .s_tvalid   (s_axis_tvalid),
    .s_tlast    (s_axis_tlast),
    .s_tready   (s_axis_tready),
    .smp_data   (tx_smp_data),
    .smp_valid  (tx_smp_valid),
    .smp_last   (tx_smp_last),
    .smp_ready  (tx_smp_ready)
  );

  align_rx_pack i_rx (
    .clk        (clk),
    .rst        (rst),
    .en         (cfg_enable),
    .cfg_size   (cfg_size),
    .cfg_left   (cfg_left),
    .cfg_packed (cfg_packed),
    .smp_data   (rx_smp_data),
    .smp_valid  (rx_smp_valid),
    .smp_last   (rx_smp_last),
    .smp_ready  (rx_smp_ready),
    .fifo_full  (fifo_full),
    .push       (push),
    .push_data  (push_data),
    .push_last  (push_last)
  );

  align_word_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk       (clk),
    .rst       (rst),
    .wr        (push),
    .wr_data   ({push_last, push_data}),
    .full      (fifo_full),
    .out_data  (fifo_out),
    .out_valid (m_axis_tvalid),
    .out_ready (m_axis_tready)
  );

  assign m_axis_tdata = fifo_out[STREAM_W-1:0];
  assign m_axis_tlast = fifo_out[STREAM_W];
endmodule

// File: tb/test_audio_align_packer.sv
module test_audio_align_packer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b1;
  logic [2:0]  cfg_size = 3'd5;
  logic        cfg_left = 1'b0;
  logic        cfg_packed = 1'b0;
  logic [31:0] s_axis_tdata = '0;
  logic        s_axis_tvalid = 1'b0;
  logic        s_axis_tlast = 1'b0;
  logic        s_axis_tready;
  logic [31:0] tx_smp_data;
  logic        tx_smp_valid;
  logic        tx_smp_last;
  logic        tx_smp_ready = 1'b0;
  logic [31:0] rx_smp_data = '0;
  logic        rx_smp_valid = 1'b0;
  logic        rx_smp_last = 1'b0;
  logic        rx_smp_ready;
  logic [31:0] m_axis_tdata;
  logic        m_axis_tvalid;
  logic        m_axis_tlast;
  logic        m_axis_tready = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  audio_align_packer i_audio_align_packer (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [2:0] sz, input logic left, input logic pk);
    @(negedge clk);
    cfg_size = sz; cfg_left = left; cfg_packed = pk;
  endtask

  task automatic tx_word(input logic [31:0] d, input logic last);
    @(negedge clk);
    s_axis_tdata = d; s_axis_tlast = last; s_axis_tvalid = 1'b1;
    while (!s_axis_tready) @(negedge clk);
    @(negedge clk);
    s_axis_tvalid = 1'b0; s_axis_tlast = 1'b0;
  endtask

  task automatic tx_expect(input string tag, input logic [31:0] d, input logic last);
    @(negedge clk);
    while (!tx_smp_valid) @(negedge clk);
    check(tag, tx_smp_data, d);
    check({tag, " last"}, {31'd0, tx_smp_last}, {31'd0, last});
    tx_smp_ready = 1'b1;
    @(negedge clk);
    tx_smp_ready = 1'b0;
  endtask

  task automatic rx_sample(input logic [31:0] d, input logic last);
    @(negedge clk);
    rx_smp_data = d; rx_smp_last = last; rx_smp_valid = 1'b1;
    while (!rx_smp_ready) @(negedge clk);
    @(negedge clk);
    rx_smp_valid = 1'b0; rx_smp_last = 1'b0;
  endtask

  task automatic rx_expect(input string tag, input logic [31:0] d, input logic last);
    @(negedge clk);
    while (!m_axis_tvalid) @(negedge clk);
    check(tag, m_axis_tdata, d);
    check({tag, " tlast"}, {31'd0, m_axis_tlast}, {31'd0, last});
    m_axis_tready = 1'b1;
    @(negedge clk);
    m_axis_tready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R13 tx valid", {31'd0, tx_smp_valid}, 32'd0);
    check("R13 m valid", {31'd0, m_axis_tvalid}, 32'd0);
    check("R13 s ready", {31'd0, s_axis_tready}, 32'd1);
    check("R13 rx ready", {31'd0, rx_smp_ready}, 32'd1);
  endtask

  task automatic t_tx_unpacked;
    set_cfg(3'd1, 1'b1, 1'b0);
    tx_word(32'h1234ABCD, 1'b0);
    tx_expect("R2 left 16", 32'h00001234, 1'b0);
    set_cfg(3'd3, 1'b0, 1'b0);
    tx_word(32'hFFF12345, 1'b1);
    tx_expect("R3 right 20 upper ignored", 32'h00012345, 1'b1);
    set_cfg(3'd0, 1'b0, 1'b0);
    tx_word(32'hAABBCC7E, 1'b0);
    tx_expect("R1 unpacked 8 one per word", 32'h0000007E, 1'b0);
    set_cfg(3'd2, 1'b1, 1'b0);
    tx_word(32'hFFFFC000, 1'b0);
    tx_expect("R2 left 18", 32'h0003FFFF, 1'b0);
  endtask

  task automatic t_tx_packed;
    set_cfg(3'd0, 1'b0, 1'b1);
    tx_word(32'h44332211, 1'b1);
    tx_expect("R6 p8 lane0", 32'h11, 1'b0);
    tx_expect("R6 p8 lane1", 32'h22, 1'b0);
    tx_expect("R6 p8 lane2", 32'h33, 1'b0);
    tx_expect("R9 R6 p8 lane3", 32'h44, 1'b1);
    set_cfg(3'd1, 1'b1, 1'b1);
    tx_word(32'h56781234, 1'b0);
    tx_expect("R6 p16 lane0", 32'h1234, 1'b0);
    tx_expect("R6 p16 lane1", 32'h5678, 1'b0);
    set_cfg(3'd4, 1'b0, 1'b1);
    tx_word(32'h77ABCDEF, 1'b0);
    tx_expect("R8 p24 one per word", 32'h00ABCDEF, 1'b0);
  endtask

  task automatic t_rx_unpacked;
    set_cfg(3'd4, 1'b1, 1'b0);
    rx_sample(32'h00ABCDEF, 1'b0);
    rx_expect("R4 left 24", 32'hABCDEF00, 1'b0);
    set_cfg(3'd2, 1'b1, 1'b0);
    rx_sample(32'h0003FFFF, 1'b1);
    rx_expect("R4 R9 left 18", 32'hFFFFC000, 1'b1);
    set_cfg(3'd3, 1'b0, 1'b0);
    rx_sample(32'h00080001, 1'b0);
    rx_expect("R5 right 20 negative", 32'hFFF80001, 1'b0);
    rx_sample(32'h00012345, 1'b0);
    rx_expect("R5 right 20 positive", 32'h00012345, 1'b0);
    set_cfg(3'd1, 1'b0, 1'b0);
    rx_sample(32'hFFFF7FFF, 1'b0);
    rx_expect("R5 right 16 upper ignored", 32'h00007FFF, 1'b0);
  endtask

  task automatic t_rx_packed;
    set_cfg(3'd0, 1'b0, 1'b1);
    rx_sample(32'h11, 1'b0);
    rx_sample(32'h22, 1'b0);
    rx_sample(32'h33, 1'b0);
    rx_sample(32'h44, 1'b0);
    rx_expect("R7 p8 full word", 32'h44332211, 1'b0);
    rx_sample(32'hAA, 1'b0);
    rx_sample(32'hBB, 1'b0);
    rx_sample(32'hCC, 1'b1);
    rx_expect("R10 R9 p8 frame end", 32'h00CCBBAA, 1'b1);
    set_cfg(3'd1, 1'b0, 1'b1);
    rx_sample(32'h1234, 1'b0);
    rx_sample(32'h5678, 1'b0);
    rx_expect("R7 p16 full word", 32'h56781234, 1'b0);
    rx_sample(32'hBEEF, 1'b1);
    rx_expect("R10 p16 frame end", 32'h0000BEEF, 1'b1);
    set_cfg(3'd3, 1'b0, 1'b1);
    rx_sample(32'h00080001, 1'b0);
    rx_expect("R8 p20 one per word", 32'hFFF80001, 1'b0);
  endtask

  task automatic t_disable;
    set_cfg(3'd0, 1'b0, 1'b1);
    rx_sample(32'h11, 1'b0);
    rx_sample(32'h22, 1'b0);
    tx_word(32'h99887766, 1'b0);
    @(negedge clk);
    cfg_enable = 1'b0;
    @(negedge clk);
    check("R11 s ready low", {31'd0, s_axis_tready}, 32'd0);
    check("R11 rx ready low", {31'd0, rx_smp_ready}, 32'd0);
    rx_expect("R11 flush padded", 32'h00002211, 1'b0);
    check("R11 tx word dropped", {31'd0, tx_smp_valid}, 32'd0);
    @(negedge clk);
    cfg_enable = 1'b1;
    @(negedge clk);
    check("R11 tx still empty", {31'd0, tx_smp_valid}, 32'd0);
  endtask

  task automatic t_backpressure;
    set_cfg(3'd5, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) rx_sample(32'hC0DE0000 + i, 1'b0);
    repeat (3) @(negedge clk);
    check("R12 rx ready low when full", {31'd0, rx_smp_ready}, 32'd0);
    check("R12 held word", m_axis_tdata, 32'hC0DE0000);
    for (int i = 0; i < 5; i++) rx_expect("R12 drain order", 32'hC0DE0000 + i, 1'b0);
    tx_word(32'h0000ABCD, 1'b0);
    repeat (4) @(negedge clk);
    check("R12 tx sample held", tx_smp_data, 32'h0000ABCD);
    tx_expect("R12 tx after stall", 32'h0000ABCD, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_tx_unpacked();
    t_tx_packed();
    t_rx_unpacked();
    t_rx_packed();
    t_disable();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule